// File: doc/BRIEF.md
# Serial CRC Frame Transmitter

This block turns a frame of octets into one serial bit stream and appends a cyclic redundancy check. The frame begins with a start pulse. Each octet then arrives on a parallel bus under a valid/ready handshake and is loaded into a shift register. The octet leaves the block on a single line, one bit per clock, most significant bit first. While the message bits go out, a linear feedback shift register divides them by the generator polynomial. The register is cleared at the start of every frame.

Once the last message bit has left, an output select moves the line from the message path to the remainder register. The remainder is then shifted out, most significant bit first and with the feedback disabled, so the check bits follow the frame directly. A one-cycle done strobe marks the end of the frame, and the block then returns to idle. The check width and the polynomial are parameters. The default is a 4-bit check with generator x^4 + x^3 + 1. A 16-bit instance with x^16 + x^15 + x^2 + 1 uses the same code.

Top module: `crc_frame_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, line_o, oct_ready_o and frame_done_o are all 0.
- R2: A start pulse accepted in the idle state clears the check register to zero, so the check of a frame never depends on an earlier frame. A frame made only of zero octets therefore yields an all-zero check.
- R3: Each accepted octet appears on line_o over 8 consecutive cycles, most significant bit first, starting in the cycle after acceptance. When the next octet is offered at the hand-off, its first bit directly follows the last bit of the previous octet.
- R4: The check is the remainder of (message * x^FCS_W) divided by the generator, computed with no initial value, no reflection and no final XOR. POLY holds the generator's coefficients below the leading term; the default is 4'b1001. Message 8'hE6 gives check 4'b0110, so the line carries 111001100110.
- R5: The FCS_W check bits are sent most significant bit first, in the FCS_W cycles immediately after the last message bit.
- R6: oct_ready_o is 1 in every cycle of the waiting state, which follows the start pulse or a stalled hand-off. It is also 1 in the cycle that carries the final bit of an octet not flagged last. It is 0 in every other cycle.
- R7: If no octet is offered when ready is high, line_o stays 0 and both shifting and the check computation pause. The frame resumes once an octet is accepted, and the result is the same as for a frame sent without the pause.
- R8: frame_done_o is 1 for exactly one cycle, the cycle after the last check bit, with line_o at 0. The block then idles with line_o and oct_ready_o at 0 until the next start pulse.
- R9: A start pulse during a frame has no effect on the line, the handshake or the check.
- R10: With FCS_W = 16 and POLY = 16'h8005, the block sends the 16-bit remainder of the same division, with the same timing rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start-of-frame pulse, honoured only in idle |
| oct_data_i | input | OCT_W | Octet to send |
| oct_valid_i | input | 1 | Octet on oct_data_i is valid |
| oct_ready_o | output | 1 | Block accepts an octet in this cycle |
| oct_last_i | input | 1 | Accompanying octet is the last of the frame |
| line_o | output | 1 | Serial line: message bits, then check bits |
| frame_done_o | output | 1 | One-cycle pulse after the last check bit |

## Verification
The bench sends every single-octet message through the 4-bit and 16-bit instances in parallel. It also sends multi-octet frames with pauses placed before the first octet and at each later hand-off, and frames with a stray start pulse in the middle. If the bench never pulsed start during a frame, a design that restarted on that pulse would pass unseen; a design whose ready lags the final bit by one cycle would leave a gap in the line, and one that keeps the check running during a pause would corrupt every later check bit. A zero frame sent after a frame with a nonzero check exposes a missing clear. Exact cycle-by-cycle comparison of the done strobe catches a check phase that is one bit too long or too short.

// File: rtl/crc_tx_pkg.sv
package crc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WAIT = 3'd1,
      ST_MSG  = 3'd2,
      ST_FCS  = 3'd3,
      ST_DONE = 3'd4
   } tx_state_e;

endpackage

// File: rtl/crc_tx_serializer.sv
module crc_tx_serializer #(
   parameter int OCT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OCT_W-1:0] data_i,
   input  logic             shift_i,
   output logic             msb_o
);

   logic [OCT_W-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (load_i) begin
         sreg_q <= data_i;
      end else if (shift_i) begin
         sreg_q <= {sreg_q[OCT_W-2:0], 1'b0};
      end
   end

   assign msb_o = sreg_q[OCT_W-1];

endmodule

// File: rtl/crc_tx_lfsr.sv
module crc_tx_lfsr #(
   parameter int               FCS_W = 4,
   parameter logic [FCS_W-1:0] POLY  = 4'b1001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic             feed_i,
   input  logic             data_bit_i,
   output logic [FCS_W-1:0] fcs_o
);

   logic [FCS_W-1:0] fcs_q;
   logic [FCS_W-1:0] fcs_nxt;
   logic             fb;

   // feedback is gated off while the remainder is being shifted out
   assign fb = feed_i & (data_bit_i ^ fcs_q[FCS_W-1]);

   for (genvar i = 0; i < FCS_W; i++) begin : g_stage
      logic prev;
      if (i == 0) begin : g_head
         assign prev = 1'b0;
      end else begin : g_body
         assign prev = fcs_q[i-1];
      end
      if (POLY[i]) begin : g_tap
         assign fcs_nxt[i] = prev ^ fb;
      end else begin : g_plain
         assign fcs_nxt[i] = prev;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcs_q <= '0;
      end else if (clear_i) begin
         fcs_q <= '0;
      end else if (step_i) begin
         fcs_q <= fcs_nxt;
      end
   end

   assign fcs_o = fcs_q;

endmodule

// File: rtl/crc_tx_ctrl.sv
module crc_tx_ctrl
   import crc_tx_pkg::*;
#(
   parameter int OCT_W = 8,
   parameter int FCS_W = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sof_i,
   input  logic      vld_i,
   input  logic      last_i,
   output logic      rdy_o,
   output logic      load_o,
   output logic      shift_o,
   output logic      clear_o,
   output logic      step_o,
   output logic      feed_o,
   output logic      msg_sel_o,
   output logic      done_o,
   output tx_state_e state_o
);

   localparam int BCW = (OCT_W > 1) ? $clog2(OCT_W) : 1;
   localparam int FCW = (FCS_W > 1) ? $clog2(FCS_W) : 1;
   localparam logic [BCW-1:0] BIT_END = BCW'(OCT_W - 1);
   localparam logic [FCW-1:0] FCS_END = FCW'(FCS_W - 1);

   tx_state_e      state_q;
   tx_state_e      state_d;
   logic [BCW-1:0] bit_q;
   logic [BCW-1:0] bit_d;
   logic [FCW-1:0] fcs_cnt_q;
   logic [FCW-1:0] fcs_cnt_d;
   logic           last_q;
   logic           last_d;
   logic           final_bit;
   logic           accept;

   assign final_bit = (state_q == ST_MSG) && (bit_q == BIT_END);
   assign rdy_o     = (state_q == ST_WAIT) || (final_bit && !last_q);
   assign accept    = rdy_o && vld_i;

   assign load_o    = accept;
   assign shift_o   = (state_q == ST_MSG);
   assign clear_o   = (state_q == ST_IDLE) && sof_i;
   assign step_o    = (state_q == ST_MSG) || (state_q == ST_FCS);
   assign feed_o    = (state_q == ST_MSG);
   assign msg_sel_o = (state_q == ST_MSG);
   assign done_o    = (state_q == ST_DONE);
   assign state_o   = state_q;

   always_comb begin
      state_d   = state_q;
      bit_d     = bit_q;
      fcs_cnt_d = fcs_cnt_q;
      last_d    = last_q;
      unique case (state_q)
         ST_IDLE: begin
            if (sof_i) begin
               state_d = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (accept) begin
               state_d = ST_MSG;
               bit_d   = '0;
               last_d  = last_i;
            end
         end
         ST_MSG: begin
            bit_d = bit_q + 1'b1;
            if (final_bit) begin
               if (last_q) begin
                  state_d   = ST_FCS;
                  fcs_cnt_d = '0;
               end else if (accept) begin
                  bit_d  = '0;
                  last_d = last_i;
               end else begin
                  state_d = ST_WAIT;
               end
            end
         end
         ST_FCS: begin
            fcs_cnt_d = fcs_cnt_q + 1'b1;
            if (fcs_cnt_q == FCS_END) begin
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_q     <= '0;
         fcs_cnt_q <= '0;
         last_q    <= 1'b0;
      end else begin
         state_q   <= state_d;
         bit_q     <= bit_d;
         fcs_cnt_q <= fcs_cnt_d;
         last_q    <= last_d;
      end
   end

endmodule

// File: rtl/crc_frame_tx.sv
module crc_frame_tx
   import crc_tx_pkg::*;
#(
   parameter int               OCT_W = 8,
   parameter int               FCS_W = 4,
   parameter logic [FCS_W-1:0] POLY  = 4'b1001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic [OCT_W-1:0] oct_data_i,
   input  logic             oct_valid_i,
   output logic             oct_ready_o,
   input  logic             oct_last_i,
   output logic             line_o,
   output logic             frame_done_o
);

   if (OCT_W < 2) begin : g_bad_octet
      $error("crc_frame_tx: OCT_W must be at least 2");
   end
   if (FCS_W < 2) begin : g_bad_width
      $error("crc_frame_tx: FCS_W must be at least 2");
   end
   if (POLY == '0) begin : g_bad_poly
      $error("crc_frame_tx: POLY must have a nonzero term");
   end

   tx_state_e        state;
   logic             load;
   logic             shift;
   logic             clear;
   logic             step;
   logic             feed;
   logic             msg_sel;
   logic             msg_bit;
   logic [FCS_W-1:0] fcs_q;

   crc_tx_ctrl #(
      .OCT_W (OCT_W),
      .FCS_W (FCS_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_i     (frame_start_i),
      .vld_i     (oct_valid_i),
      .last_i    (oct_last_i),
      .rdy_o     (oct_ready_o),
      .load_o    (load),
      .shift_o   (shift),
      .clear_o   (clear),
      .step_o    (step),
      .feed_o    (feed),
      .msg_sel_o (msg_sel),
      .done_o    (frame_done_o),
      .state_o   (state)
   );

   crc_tx_serializer #(
      .OCT_W (OCT_W)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .data_i  (oct_data_i),
      .shift_i (shift),
      .msb_o   (msg_bit)
   );

   crc_tx_lfsr #(
      .FCS_W (FCS_W),
      .POLY  (POLY)
   ) u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear),
      .step_i     (step),
      .feed_i     (feed),
      .data_bit_i (msg_bit),
      .fcs_o      (fcs_q)
   );

   // output select: message path, remainder path, or quiet line
   always_comb begin
      if (msg_sel) begin
         line_o = msg_bit;
      end else if (state == ST_FCS) begin
         line_o = fcs_q[FCS_W-1];
      end else begin
         line_o = 1'b0;
      end
   end

endmodule

// File: rtl/crc_frame_tx_chk.sv
module crc_frame_tx_chk
   import crc_tx_pkg::*;
#(
   parameter int FCS_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sof_i,
   input logic             vld_i,
   input logic             rdy_i,
   input logic             line_i,
   input logic             done_i,
   input tx_state_e        state_i,
   input logic [FCS_W-1:0] fcs_i
);

   // R2
   fcs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_IDLE && sof_i) |=> (fcs_i == '0));

   // R6
   rdy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_i |-> (state_i == ST_WAIT || state_i == ST_MSG));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_WAIT && !vld_i) |=> $stable(fcs_i));

   // R7
   quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_WAIT || state_i == ST_IDLE) |-> !line_i);

   // R5
   fcs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_FCS) |=> (state_i == ST_FCS || state_i == ST_DONE));

   // R8
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (!done_i && state_i == ST_IDLE));

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (!line_i && !rdy_i));

endmodule

bind crc_frame_tx crc_frame_tx_chk #(.FCS_W(FCS_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sof_i   (frame_start_i),
   .vld_i   (oct_valid_i),
   .rdy_i   (oct_ready_o),
   .line_i  (line_o),
   .done_i  (frame_done_o),
   .state_i (state),
   .fcs_i   (fcs_q)
);

// File: tb/crc_frame_tx_test.sv
module crc_frame_tx_test;

   localparam int TMAX = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof = 1'b0;
   logic       vld = 1'b0;
   logic       last = 1'b0;
   logic [7:0] dat = 8'h00;
   wire        rdy4, ser4, done4, rdy16, ser16, done16;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] msg [4];
   bit         t_sof [TMAX];
   bit         t_vld [TMAX];
   bit         t_last[TMAX];
   logic [7:0] t_dat [TMAX];
   bit         e_rdy [TMAX];
   bit         e_s4  [TMAX];
   bit         e_d4  [TMAX];
   bit         e_s16 [TMAX];
   bit         e_d16 [TMAX];
   int         t_ph  [TMAX];
   int         tlen;
   int         fcs_at;
   string      ftag;
   logic [63:0] line4;

   always #2 clk = ~clk;

   crc_frame_tx uut (
      .clk(clk), .rst_n(rst_n), .frame_start_i(sof), .oct_data_i(dat),
      .oct_valid_i(vld), .oct_ready_o(rdy4), .oct_last_i(last),
      .line_o(ser4), .frame_done_o(done4)
   );

   crc_frame_tx #(.FCS_W(16), .POLY(16'h8005)) uut_w16 (
      .clk(clk), .rst_n(rst_n), .frame_start_i(sof), .oct_data_i(dat),
      .oct_valid_i(vld), .oct_ready_o(rdy16), .oct_last_i(last),
      .line_o(ser16), .frame_done_o(done16)
   );

   task automatic check(string tag, longint got, longint exp, string what);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // long division of the zero-augmented message, bit by bit
   function automatic logic [15:0] crc_ref(int w, logic [15:0] poly, int nb);
      logic [16:0] r;
      logic [16:0] gen;
      r   = '0;
      gen = (17'd1 << w) | {1'b0, poly};
      for (int i = 0; i < nb * 8 + w; i++) begin
         logic b;
         b = (i < nb * 8) ? msg[i / 8][7 - (i % 8)] : 1'b0;
         r = (r << 1) | {16'd0, b};
         if (r[w]) r = r ^ gen;
      end
      return r[15:0];
   endfunction

   task automatic offer(int c, int k, int nb);
      t_vld[c]  = 1'b1;
      t_dat[c]  = msg[k];
      t_last[c] = (k == nb - 1);
   endtask

   task automatic build(int nb, int gap_at, int gap_len, int sof_mid);
      int c;
      logic [15:0] f4, f16;
      for (int i = 0; i < TMAX; i++) begin
         t_sof[i] = 0; t_vld[i] = 0; t_last[i] = 0; t_dat[i] = 8'h00;
         e_rdy[i] = 0; e_s4[i] = 0; e_d4[i] = 0; e_s16[i] = 0; e_d16[i] = 0;
         t_ph[i] = 0;
      end
      f4  = crc_ref(4, 16'h0009, nb);
      f16 = crc_ref(16, 16'h8005, nb);
      t_sof[0] = 1'b1;
      c = 1;
      if (gap_at == 0) begin
         for (int g = 0; g < gap_len; g++) begin e_rdy[c] = 1; c++; end
      end
      e_rdy[c] = 1;
      offer(c, 0, nb);
      c++;
      for (int k = 0; k < nb; k++) begin
         for (int b = 0; b < 8; b++) begin
            e_s4[c]  = msg[k][7 - b];
            e_s16[c] = msg[k][7 - b];
            t_ph[c]  = 1;
            if (b == 7 && k < nb - 1) begin
               e_rdy[c] = 1;
               if (gap_at == k + 1 && gap_len > 0) begin
                  for (int g = 0; g < gap_len; g++) begin c++; e_rdy[c] = 1; end
               end
               offer(c, k + 1, nb);
            end
            c++;
         end
      end
      fcs_at = c;
      for (int j = 0; j < 16; j++) begin
         t_ph[c + j]  = 2;
         e_s16[c + j] = f16[15 - j];
         if (j < 4) e_s4[c + j] = f4[3 - j];
      end
      e_d4[c + 4]   = 1;
      e_d16[c + 16] = 1;
      t_ph[c + 16]  = 3;
      tlen = c + 18;
      if (sof_mid > 0) t_sof[sof_mid] = 1'b1;
   endtask

   task automatic run();
      string s4, s16;
      line4 = '0;
      for (int c = 0; c < tlen; c++) begin
         @(negedge clk);
         if (t_ph[c] == 1) begin
            s4 = "R3"; s16 = "R3";
         end else if (t_ph[c] == 2) begin
            s4 = (c < fcs_at + 4) ? "R4/R5" : "R8"; s16 = "R10";
         end else begin
            s4 = "R8"; s16 = "R8";
         end
         check({"R6 ", ftag}, rdy4, e_rdy[c], $sformatf("ready w4 cyc %0d", c));
         check({"R6 ", ftag}, rdy16, e_rdy[c], $sformatf("ready w16 cyc %0d", c));
         check({s4, " ", ftag}, ser4, e_s4[c], $sformatf("line w4 cyc %0d", c));
         check({s16, " ", ftag}, ser16, e_s16[c], $sformatf("line w16 cyc %0d", c));
         check({"R5/R8 ", ftag}, done4, e_d4[c], $sformatf("done w4 cyc %0d", c));
         check({"R8 R10 ", ftag}, done16, e_d16[c], $sformatf("done w16 cyc %0d", c));
         if (t_ph[c] == 1 || (c >= fcs_at && c < fcs_at + 4)) line4 = {line4[62:0], ser4};
         sof  = t_sof[c];
         vld  = t_vld[c];
         dat  = t_dat[c];
         last = t_last[c];
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", {ser4, rdy4, done4}, 0, "outputs w4 in reset");
      check("R1", {ser16, rdy16, done16}, 0, "outputs w16 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {ser4, rdy4, done4}, 0, "outputs w4 after reset");
      // R8 idle: an offered octet without a start pulse is not taken
      vld = 1'b1; dat = 8'hFF; last = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R8 idle", {ser4, rdy4, done4, ser16, rdy16}, 0, "idle outputs");
      end
      vld = 1'b0; last = 1'b0;

      // R4 worked example
      msg[0] = 8'hE6;
      ftag = "R4";
      build(1, -1, 0, 0);
      check("R4", crc_ref(4, 16'h0009, 1), 16'h0006, "reference remainder of E6");
      run();
      check("R4", line4[11:0], 12'b111001100110, "serial stream for E6");

      // R2: zero frame after a frame with a nonzero check
      msg[0] = 8'h00;
      ftag = "R2";
      build(1, -1, 0, 0);
      run();
      check("R2", line4[3:0], 4'b0000, "check of zero frame after E6");

      // R3 R4 R10: every single-octet message
      ftag = "";
      for (int v = 0; v < 256; v++) begin
         msg[0] = 8'(v);
         build(1, -1, 0, 0);
         run();
      end

      // R3 R6: back-to-back multi-octet frames
      for (int nb = 2; nb <= 4; nb++) begin
         for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < 4; k++) begin
               seed = seed * 32'd1103515245 + 32'd12345;
               msg[k] = seed[23:16];
            end
            ftag = "R3";
            build(nb, -1, 0, 0);
            run();
         end
      end

      // R7: pauses before the first octet and at each hand-off
      for (int nb = 1; nb <= 4; nb++) begin
         for (int ga = 0; ga < nb; ga++) begin
            for (int gl = 1; gl <= 3; gl++) begin
               for (int k = 0; k < 4; k++) begin
                  seed = seed * 32'd1103515245 + 32'd12345;
                  msg[k] = seed[23:16];
               end
               ftag = "R7";
               build(nb, ga, gl, 0);
               run();
            end
         end
      end

      // R9: stray start pulse inside message and check phases
      for (int p = 3; p < 30; p += 4) begin
         for (int k = 0; k < 4; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            msg[k] = seed[23:16];
         end
         ftag = "R9";
         build(3, -1, 0, p);
         run();
      end

      report();
   end

endmodule